// File: doc/BRIEF.md
# Dual-Instruction Word Sequencer

This block steps a program through memory words that each pack two 24-bit instructions into 48 bits. A program counter provides the address of the word to fetch. The block raises a fetch request and waits, for as many cycles as needed, until the memory signals that the word is present. It then stores the word in a control register and presents its two halves to the execution logic one after the other. The high half (bits 47:24) goes first and the low half (bits 23:0) second.

The execution logic reports the end of each instruction with a done strobe. Two qualifiers arrive with that strobe: a jump flag with a target address, and a skip flag. A jump or a skip raised by the high half cancels the low half. A jump replaces the counter contents with the target. When no jump is taken, the counter advances by one once the word is finished. Memory is split into an even bank and an odd bank of 2^(ADDR_W-1) words each. Address bit 0 picks the bank, and each bank holds its own word-address register. Decoding and executing the instructions are not part of this block.

Top module: `dual_word_sequencer`

## Requirements
- R1: While reset is asserted and right after it is released, fetch_req is 1, fetch_addr is 0, instr_valid is 0, even_sel is 1 and odd_sel is 0.
- R2: While fetch_req is 1 and mem_valid is 0, fetch_req stays 1 and fetch_addr stays unchanged.
- R3: On the cycle after a clock edge where fetch_req and mem_valid are both 1, instr_valid is 1, instr_upper is 1 and instr equals bits 47:24 of the accepted mem_rdata.
- R4: When the high half completes (exec_done with instr_valid and instr_upper) with jump_taken 0 and skip_lower 0, the next cycle presents the low half: instr_valid 1, instr_upper 0, instr equal to bits 23:0 of the stored word.
- R5: When a word finishes without a jump, the next cycle shows fetch_req 1 with fetch_addr equal to the previous address plus one, modulo 2^ADDR_W, so 0x7FFF goes to 0.
- R6: A jump on the high half cancels the low half. The next cycle shows fetch_req 1 with fetch_addr equal to jump_target.
- R7: A skip without a jump on the high half cancels the low half. The next cycle shows fetch_req 1 with fetch_addr equal to the previous address plus one.
- R8: A jump on the low half loads jump_target in place of the increment. The next cycle shows fetch_req 1 at that target.
- R9: When jump_taken and skip_lower are both 1 on the high half, the jump wins and the next fetch is from jump_target.
- R10: skip_lower on the low half has no effect. The next fetch is from the previous address plus one.
- R11: While fetch_req is 1, exactly one bank select is 1: odd_sel when fetch_addr bit 0 is 1, even_sel otherwise. The selected bank's address register equals fetch_addr bits 14:1.
- R12: mem_valid while an instruction is being presented, and exec_done while a fetch is pending, are both ignored. The instruction, the fetch address and the state are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | input | 1 | Memory word present on mem_rdata |
| mem_rdata | input | 48 | Fetched instruction word |
| exec_done | input | 1 | Current instruction has finished |
| jump_taken | input | 1 | Finished instruction is a taken jump |
| skip_lower | input | 1 | Finished high instruction skips the low one |
| jump_target | input | 15 | Jump destination address |
| fetch_req | output | 1 | Word fetch pending |
| fetch_addr | output | 15 | Program counter / fetch address |
| even_sel | output | 1 | Even bank selected for the pending fetch |
| odd_sel | output | 1 | Odd bank selected for the pending fetch |
| even_addr | output | 14 | Even bank word-address register |
| odd_addr | output | 14 | Odd bank word-address register |
| instr_valid | output | 1 | An instruction is being presented |
| instr_upper | output | 1 | Presented instruction is the high half |
| instr | output | 24 | Presented instruction |

## Verification
A jump and a skip can both be reported on the same done strobe of the high half. The vector table contains a word that raises both flags at once, and the test passes only if the next fetch address is the jump target and the low half is never presented. A second collision is a jump on the low half, which lands on the same edge as the normal increment. The bench computes the expected address on its own and compares it against the target to judge that the jump replaced the increment. Stray mem_valid and exec_done pulses in the wrong phase are driven directly to show they have no effect.

// File: rtl/dws_pkg.sv
package dws_pkg;

  localparam int unsigned DWS_ADDR_W = 15;
  localparam int unsigned DWS_HALF_W = 24;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'd0,
    SEQ_HIGH  = 2'd1,
    SEQ_LOW   = 2'd2
  } seq_phase_e;

endpackage

// File: rtl/dws_pc.sv
module dws_pc #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              jump,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] pc_next
);

  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] cur,
    input logic              take_jump,
    input logic [ADDR_W-1:0] dest
  );
    if (take_jump) return dest;
    return cur + ADDR_W'(1);
  endfunction

  assign pc_next = step_addr(pc_q, jump, target);

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (load_en) pc_q <= pc_next;
  end

endmodule

// File: rtl/dws_ctrl_reg.sv
module dws_ctrl_reg #(
  parameter int unsigned HALF_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                capture,
  input  logic [2*HALF_W-1:0] word_in,
  input  logic                pick_low,
  output logic [HALF_W-1:0]   instr_out
);

  localparam int unsigned WORD_W = 2 * HALF_W;

  logic [WORD_W-1:0] word_q;

  function automatic logic [HALF_W-1:0] half_of(
    input logic [WORD_W-1:0] w,
    input logic              low
  );
    if (low) return w[HALF_W-1:0];
    return w[WORD_W-1:HALF_W];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       word_q <= '0;
    else if (capture) word_q <= word_in;
  end

  assign instr_out = half_of(word_q, pick_low);

endmodule

// File: rtl/dws_bank_route.sv
module dws_bank_route #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr_next,
  input  logic              fetch_on,
  input  logic [ADDR_W-1:0] addr_cur,
  output logic              even_sel,
  output logic              odd_sel,
  output logic [ADDR_W-2:0] even_addr,
  output logic [ADDR_W-2:0] odd_addr
);

  localparam int unsigned BANK_AW = ADDR_W - 1;
  localparam int unsigned N_BANKS = 2;

  logic [BANK_AW-1:0] bank_addr_q [N_BANKS];
  logic [N_BANKS-1:0] bank_sel;

  function automatic logic bank_is_odd(input logic [ADDR_W-1:0] a);
    return a[0];
  endfunction

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic hit_next;
    assign hit_next    = (bank_is_odd(addr_next) == (b == 1));
    assign bank_sel[b] = fetch_on && (bank_is_odd(addr_cur) == (b == 1));
    always_ff @(posedge clk) begin
      if (!rst_n)                   bank_addr_q[b] <= '0;
      else if (load_en && hit_next) bank_addr_q[b] <= addr_next[ADDR_W-1:1];
    end
  end

  assign even_sel  = bank_sel[0];
  assign odd_sel   = bank_sel[1];
  assign even_addr = bank_addr_q[0];
  assign odd_addr  = bank_addr_q[1];

endmodule

// File: rtl/dual_word_sequencer.sv
module dual_word_sequencer
  import dws_pkg::*;
#(
  parameter int unsigned ADDR_W = DWS_ADDR_W,
  parameter int unsigned HALF_W = DWS_HALF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mem_valid,
  input  logic [2*HALF_W-1:0] mem_rdata,
  input  logic                exec_done,
  input  logic                jump_taken,
  input  logic                skip_lower,
  input  logic [ADDR_W-1:0]   jump_target,
  output logic                fetch_req,
  output logic [ADDR_W-1:0]   fetch_addr,
  output logic                even_sel,
  output logic                odd_sel,
  output logic [ADDR_W-2:0]   even_addr,
  output logic [ADDR_W-2:0]   odd_addr,
  output logic                instr_valid,
  output logic                instr_upper,
  output logic [HALF_W-1:0]   instr
);

  seq_phase_e        phase_q, phase_d;
  logic [ADDR_W-1:0] pc_q, pc_next;

  // Named events, also watched by the checker
  logic word_accept;
  logic step_done;
  logic upper_cancel;
  logic lower_issue;
  logic word_retire;

  assign fetch_req   = (phase_q == SEQ_FETCH);
  assign instr_valid = (phase_q == SEQ_HIGH) || (phase_q == SEQ_LOW);
  assign instr_upper = (phase_q == SEQ_HIGH);

  assign word_accept  = fetch_req && mem_valid;
  assign step_done    = instr_valid && exec_done;
  assign upper_cancel = step_done && instr_upper && (jump_taken || skip_lower);
  assign lower_issue  = step_done && instr_upper && !jump_taken && !skip_lower;
  assign word_retire  = step_done && !lower_issue;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      SEQ_FETCH: if (word_accept) phase_d = SEQ_HIGH;
      SEQ_HIGH: begin
        if (lower_issue)      phase_d = SEQ_LOW;
        else if (word_retire) phase_d = SEQ_FETCH;
      end
      SEQ_LOW:   if (step_done) phase_d = SEQ_FETCH;
      default:   phase_d = SEQ_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= SEQ_FETCH;
    else        phase_q <= phase_d;
  end

  dws_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (word_retire),
    .jump    (jump_taken),
    .target  (jump_target),
    .pc_q    (pc_q),
    .pc_next (pc_next)
  );

  dws_ctrl_reg #(.HALF_W(HALF_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (word_accept),
    .word_in   (mem_rdata),
    .pick_low  (phase_q == SEQ_LOW),
    .instr_out (instr)
  );

  dws_bank_route #(.ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (word_retire),
    .addr_next (pc_next),
    .fetch_on  (fetch_req),
    .addr_cur  (pc_q),
    .even_sel  (even_sel),
    .odd_sel   (odd_sel),
    .even_addr (even_addr),
    .odd_addr  (odd_addr)
  );

  assign fetch_addr = pc_q;

endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned HALF_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mem_valid,
  input logic [2*HALF_W-1:0] mem_rdata,
  input logic                exec_done,
  input logic                jump_taken,
  input logic                skip_lower,
  input logic [ADDR_W-1:0]   jump_target,
  input logic                fetch_req,
  input logic [ADDR_W-1:0]   fetch_addr,
  input logic                even_sel,
  input logic                odd_sel,
  input logic [ADDR_W-2:0]   even_addr,
  input logic [ADDR_W-2:0]   odd_addr,
  input logic                instr_valid,
  input logic                instr_upper,
  input logic [HALF_W-1:0]   instr,
  input logic                upper_cancel,
  input logic                lower_issue,
  input logic                word_retire
);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !mem_valid |=> fetch_req && $stable(fetch_addr));

  assert_high_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && mem_valid |=> instr_valid && instr_upper
      && instr == $past(mem_rdata[2*HALF_W-1:HALF_W]));

  assert_low_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lower_issue |=> instr_valid && !instr_upper);

  assert_seq_increment_R5: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !instr_upper && exec_done && !jump_taken
      |=> fetch_req && fetch_addr == $past(fetch_addr) + ADDR_W'(1));

  assert_jump_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && exec_done && jump_taken
      |=> fetch_req && fetch_addr == $past(jump_target));

  assert_skip_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upper_cancel && !jump_taken
      |=> fetch_req && fetch_addr == $past(fetch_addr) + ADDR_W'(1));

  assert_bank_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> $onehot({even_sel, odd_sel}) && odd_sel == fetch_addr[0]);

  assert_bank_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (odd_sel ? odd_addr : even_addr) == fetch_addr[ADDR_W-1:1]);

  assert_idle_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |-> !even_sel && !odd_sel);

  assert_phase_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && instr_valid));

  assert_stray_mem_R12: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !exec_done |=> instr_valid && $stable(instr) && $stable(instr_upper));

  assert_retire_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_retire |=> !word_retire);

endmodule

bind dual_word_sequencer dws_checker #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_dws_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_valid    (mem_valid),
  .mem_rdata    (mem_rdata),
  .exec_done    (exec_done),
  .jump_taken   (jump_taken),
  .skip_lower   (skip_lower),
  .jump_target  (jump_target),
  .fetch_req    (fetch_req),
  .fetch_addr   (fetch_addr),
  .even_sel     (even_sel),
  .odd_sel      (odd_sel),
  .even_addr    (even_addr),
  .odd_addr     (odd_addr),
  .instr_valid  (instr_valid),
  .instr_upper  (instr_upper),
  .instr        (instr),
  .upper_cancel (upper_cancel),
  .lower_issue  (lower_issue),
  .word_retire  (word_retire)
);

// File: tb/test_dual_word_sequencer.sv
module test_dual_word_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_valid = 1'b0;
  logic [47:0] mem_rdata = '0;
  logic        exec_done = 1'b0;
  logic        jump_taken = 1'b0;
  logic        skip_lower = 1'b0;
  logic [14:0] jump_target = '0;
  logic        fetch_req;
  logic [14:0] fetch_addr;
  logic        even_sel, odd_sel;
  logic [13:0] even_addr, odd_addr;
  logic        instr_valid, instr_upper;
  logic [23:0] instr;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  dual_word_sequencer i_dual_word_sequencer (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .exec_done(exec_done), .jump_taken(jump_taken), .skip_lower(skip_lower),
    .jump_target(jump_target), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .even_sel(even_sel), .odd_sel(odd_sel), .even_addr(even_addr),
    .odd_addr(odd_addr), .instr_valid(instr_valid), .instr_upper(instr_upper),
    .instr(instr)
  );

  // Vector: {word[47:0], high_act[1:0], high_tgt[14:0], low_act[1:0], low_tgt[14:0]}
  // act bit0 = jump, bit1 = skip
  localparam logic [81:0] VEC [8] = '{
    {48'hA1A1A1_B2B2B2, 2'd0, 15'h5555, 2'd0, 15'h2222},
    {48'h111111_222222, 2'd1, 15'h1235, 2'd0, 15'h0000},
    {48'h333333_444444, 2'd2, 15'h0777, 2'd0, 15'h0000},
    {48'h555555_666666, 2'd0, 15'h0000, 2'd1, 15'h7FFF},
    {48'h777777_888888, 2'd0, 15'h1111, 2'd0, 15'h3333},
    {48'h999999_AAAAAA, 2'd3, 15'h0040, 2'd0, 15'h0000},
    {48'hBBBBBB_CCCCCC, 2'd0, 15'h0000, 2'd2, 15'h0100},
    {48'hDDDDDD_EEEEEE, 2'd0, 15'h0000, 2'd1, 15'h2AAA}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_fetch(input string tag, input logic [14:0] exp_addr);
    chk(tag, {63'd0, fetch_req}, 64'd1);
    chk(tag, {49'd0, fetch_addr}, {49'd0, exp_addr});
    chk("R11 sel", {62'd0, odd_sel, even_sel}, exp_addr[0] ? 64'd2 : 64'd1);
    chk("R11 addr", {50'd0, (exp_addr[0] ? odd_addr : even_addr)}, {50'd0, exp_addr[14:1]});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [14:0] pc;
    // R1: reset state
    tick(); tick();
    chk("R1 req", {63'd0, fetch_req}, 64'd1);
    chk("R1 addr", {49'd0, fetch_addr}, 64'd0);
    chk("R1 valid", {63'd0, instr_valid}, 64'd0);
    chk("R1 sel", {62'd0, odd_sel, even_sel}, 64'd1);
    rst_n = 1'b1;
    #1;
    chk("R1 release", {48'd0, fetch_req, fetch_addr}, {48'd0, 1'b1, 15'd0});
    pc = '0;

    for (int i = 0; i < 8; i++) begin
      logic [47:0] w;
      logic [1:0]  ua, la;
      logic [14:0] ut, lt, nxt;
      string       tag;
      {w, ua, ut, la, lt} = VEC[i];
      chk_fetch("R11 fetch", pc);
      tick(); // stall one cycle
      chk("R2 stall", {48'd0, fetch_req, fetch_addr}, {48'd0, 1'b1, pc});
      mem_valid = 1'b1; mem_rdata = w;
      tick();
      mem_valid = 1'b0;
      chk("R3 high", {39'd0, instr_valid, instr_upper, instr}, {39'd0, 2'b11, w[47:24]});
      exec_done = 1'b1; jump_taken = ua[0]; skip_lower = ua[1]; jump_target = ut;
      tick();
      exec_done = 1'b0; jump_taken = 1'b0; skip_lower = 1'b0;
      if (ua[0]) begin
        nxt = ut; tag = (ua[1]) ? "R9 jump over skip" : "R6 high jump";
      end else if (ua[1]) begin
        nxt = pc + 15'd1; tag = "R7 high skip";
      end else begin
        chk("R4 low", {39'd0, instr_valid, instr_upper, instr}, {39'd0, 2'b10, w[23:0]});
        exec_done = 1'b1; jump_taken = la[0]; skip_lower = la[1]; jump_target = lt;
        tick();
        exec_done = 1'b0; jump_taken = 1'b0; skip_lower = 1'b0;
        if (la[0])      begin nxt = lt;          tag = "R8 low jump"; end
        else if (la[1]) begin nxt = pc + 15'd1;  tag = "R10 low skip ignored"; end
        else            begin nxt = pc + 15'd1;  tag = "R5 increment"; end
      end
      chk(tag, {48'd0, fetch_req, fetch_addr}, {48'd0, 1'b1, nxt});
      chk("R12 no instr", {63'd0, instr_valid}, 64'd0);
      pc = nxt;
    end

    // R12: exec_done during fetch ignored
    exec_done = 1'b1; jump_taken = 1'b1; jump_target = 15'h0ABC;
    tick();
    exec_done = 1'b0; jump_taken = 1'b0;
    chk("R12 done in fetch", {47'd0, fetch_req, instr_valid, fetch_addr}, {47'd0, 2'b10, pc});
    // R12: mem_valid during presentation ignored
    mem_valid = 1'b1; mem_rdata = 48'h123456_654321;
    tick();
    mem_rdata = 48'hFEDCBA_0F0F0F;
    tick();
    mem_valid = 1'b0;
    chk("R12 stray mem", {39'd0, instr_valid, instr_upper, instr}, {39'd0, 2'b11, 24'h123456});
    exec_done = 1'b1;
    tick();
    exec_done = 1'b0;
    chk("R12 kept low", {40'd0, instr_upper, instr}, {40'd0, 1'b0, 24'h654321});

    // R1: reset in mid-word
    rst_n = 1'b0;
    tick();
    chk("R1 midreset", {46'd0, fetch_req, instr_valid, even_sel, fetch_addr},
        {46'd0, 3'b101, 15'd0});
    rst_n = 1'b1;
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule